// File: doc/BRIEF.md
# One-bit bitstream DC blocker

This block takes a one-bit, sigma-delta encoded sample stream and returns a one-bit stream from which the DC content has been removed. Each input bit stands for +1 or -1. The block is a delta-modulator loop. Its feedback path holds an integrator of the output and a small inner sigma-delta modulator. That inner modulator has one or two integrators, selected by a parameter. The feedback bit it produces is subtracted from the input. A first-order error-feedback requantiser then turns the difference back into a single bit. The signal transfer function has a zero at DC. Its second zero and its two poles are set by two gain constants, alpha and beta.

The block contains no multiplier. Every gain-times-bit product is a multiplexer that picks either the stored gain or its stored negation, steered by a one-bit decision. The multi-bit state is held in narrow, saturating accumulators. The block advances one sample per cycle in which the input strobe is high. The gains reset to built-in defaults and can be replaced at run time.

Top module: `bitstream_dc_blocker`

## Requirements
- R1: A bit value of 1 means +1 and a bit value of 0 means -1, on the input, the output and the internal feedback bit. Every quantiser returns 1 when its node is zero or positive and 0 otherwise.
- R2: Synchronous reset sets every accumulator to zero, sets the output bit and the feedback bit to 1, and restores the default gains.
- R3: A cycle with `valid_i` low changes no state, so the input bit in that cycle is ignored and `bit_o` holds its value.
- R4: The output is registered. The value on `bit_o` after sample step n is the sign of the output requantiser node computed in step n, and it is the output value used inside step n+1.
- R5: With one inner integrator, each step with input x, output y and feedback bit s performs the following, using the new value of A: A ← sat(A + alpha·y); V1 ← sat(V1 + A − beta·s); s ← sign(V1); U ← sat(U + x − s − y); y ← sign(U). Here alpha·y and beta·s are taken in units of 2^-9, and U is taken in units of 1.
- R6: With two inner integrators, the following is added: V2 ← sat(V2 + V1old − beta·s), where V1old is the value of V1 before the step. The feedback bit is then the sign of the new V2 instead of V1.
- R7: Gains are 10-bit two's-complement values with 9 fractional bits. The default codes are the nearest integers to 512·gain: alpha=10 and beta=138 (0.0205 and 0.2705) for one inner integrator, and alpha=7 and beta=26 (0.0127 and 0.0508) for two.
- R8: A cycle with `load_i` high replaces both gains with `alpha_i` and `beta_i`. A sample step taken in that same cycle still uses the old gains. The negation of the most negative code saturates to the most positive code.
- R9: Every accumulator saturates at -512 and +511 instead of wrapping.
- R10: For an input encoding 0.5 DC plus a 0.5-amplitude tone, the mean of the output over 4096 settled samples (one sample being ±1) lies within ±0.125, while the input mean is near 0.5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Input strobe; one sample step per high cycle |
| bit_i | input | 1 | Input sample, 1 = +1, 0 = -1 |
| load_i | input | 1 | Replace both gains with alpha_i and beta_i |
| alpha_i | input | 10 | New alpha gain, signed, 9 fractional bits |
| beta_i | input | 10 | New beta gain, signed, 9 fractional bits |
| bit_o | output | 1 | Output sample, 1 = +1, 0 = -1 |

## Verification
A gain load and a sample step can fall in the same cycle. The step must still use the old gains, and the new ones apply from the next step. The bench provokes this by asserting `load_i` together with `valid_i`, and again with `valid_i` low. Both DUT instances are judged bit for bit against an independent fixed-point model that swaps its gains only after modelling the step. A second pairing is saturation coinciding with a quantiser decision. A large alpha and a zero beta drive the inner integrator into its ceiling while steps continue, and a wrapped value would flip the feedback bit and change the output stream.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    // Signed value of a stream bit: 1 -> +1, 0 -> -1.
    function automatic int bit_val(logic b);
        return b ? 1 : -1;
    endfunction

    // Clamp an integer to the range of a w-bit two's-complement word.
    function automatic int clamp_int(int v, int w);
        int hi;
        int lo;
        hi = (1 << (w - 1)) - 1;
        lo = -(1 << (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/dcb_gain_reg.sv
module dcb_gain_reg #(
    parameter int W       = 10,
    parameter int RST_VAL = 0
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                load_i,
    input  logic signed [W-1:0] val_i,
    output logic signed [W-1:0] pos_o,
    output logic signed [W-1:0] neg_o
);
    import dcb_pkg::*;

    localparam int GMIN = -(2 ** (W - 1));

    typedef struct packed {
        logic signed [W-1:0] pos;
        logic signed [W-1:0] neg;
    } gain_t;

    gain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.pos = val_i;
            st_d.neg = W'(clamp_int(-int'(val_i), W));
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.pos <= W'(RST_VAL);
            st_q.neg <= W'(clamp_int(-RST_VAL, W));
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o = st_q.pos;
    assign neg_o = st_q.neg;

    // R8: stored pair always sums to zero unless the positive copy is the most negative code
    a_r8_neg_pair: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(st_q.pos) + int'(st_q.neg) == 0) || (int'(st_q.pos) == GMIN));

endmodule

// File: rtl/dcb_sign_mux.sv
module dcb_sign_mux #(
    parameter int W = 10
) (
    input  logic                sel_i,
    input  logic signed [W-1:0] pos_i,
    input  logic signed [W-1:0] neg_i,
    output logic signed [W-1:0] prod_o
);
    // Gain times a +/-1 bit: pick the constant or its stored negation.
    assign prod_o = sel_i ? pos_i : neg_i;
endmodule

// File: rtl/dcb_inner_mod.sv
module dcb_inner_mod #(
    parameter int W     = 10,
    parameter int ORDER = 1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                en_i,
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] bprod_i,
    output logic                fb_o
);
    import dcb_pkg::*;

    localparam int WMAX = 2 ** (W - 1) - 1;

    typedef struct packed {
        logic signed [W-1:0] w1;
        logic signed [W-1:0] w2;
        logic                fb;
    } inner_t;

    inner_t st_d, st_q;
    logic signed [W-1:0] w1_cand, w2_cand, node;

    always_comb begin
        w1_cand = W'(clamp_int(int'(st_q.w1) + int'(a_i) - int'(bprod_i), W));
        w2_cand = W'(clamp_int(int'(st_q.w2) + int'(st_q.w1) - int'(bprod_i), W));
    end

    generate
        if (ORDER == 1) begin : g_first
            assign node = w1_cand;
        end else begin : g_second
            assign node = w2_cand;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.w1 = w1_cand;
            st_d.w2 = w2_cand;
            st_d.fb = ~node[W-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.w1 <= '0;
            st_q.w2 <= '0;
            st_q.fb <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_o = st_q.fb;

    // R3: feedback decision only moves on a sample step
    a_r3_fb_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(fb_o));

    // R9: first integrator pinned at its ceiling stays there for a non-negative increment
    a_r9_w1_ceiling: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i && (int'(st_q.w1) == WMAX) && (int'(a_i) >= int'(bprod_i))
        |=> int'(st_q.w1) == WMAX);

endmodule

// File: rtl/bitstream_dc_blocker.sv
module bitstream_dc_blocker #(
    parameter int  LOOP_ORDER = 1,
    parameter int  ST_W       = 10,
    parameter int  GAIN_FRAC  = 9,
    parameter real DEF_ALPHA  = (LOOP_ORDER == 1) ? 0.0205 : 0.0127,
    parameter real DEF_BETA   = (LOOP_ORDER == 1) ? 0.2705 : 0.0508
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   valid_i,
    input  logic                   bit_i,
    input  logic                   load_i,
    input  logic signed [ST_W-1:0] alpha_i,
    input  logic signed [ST_W-1:0] beta_i,
    output logic                   bit_o
);
    import dcb_pkg::*;

    localparam int ALPHA_CODE = int'(DEF_ALPHA * real'(2 ** GAIN_FRAC));
    localparam int BETA_CODE  = int'(DEF_BETA * real'(2 ** GAIN_FRAC));
    localparam int AMAX       = 2 ** (ST_W - 1) - 1;

    typedef struct packed {
        logic signed [ST_W-1:0] acc_a;
        logic signed [ST_W-1:0] acc_u;
        logic                   y;
    } outer_t;

    outer_t st_d, st_q;

    logic signed [ST_W-1:0] ga_pos, ga_neg, gb_pos, gb_neg;
    logic signed [ST_W-1:0] prod_a, prod_b, a_cand;
    logic                   fb_bit;
    int                     u_sum;

    dcb_gain_reg #(.W(ST_W), .RST_VAL(ALPHA_CODE)) u_alpha (
        .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i), .val_i(alpha_i),
        .pos_o(ga_pos), .neg_o(ga_neg)
    );

    dcb_gain_reg #(.W(ST_W), .RST_VAL(BETA_CODE)) u_beta (
        .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i), .val_i(beta_i),
        .pos_o(gb_pos), .neg_o(gb_neg)
    );

    dcb_sign_mux #(.W(ST_W)) u_mux_a (
        .sel_i(st_q.y), .pos_i(ga_pos), .neg_i(ga_neg), .prod_o(prod_a)
    );

    dcb_sign_mux #(.W(ST_W)) u_mux_b (
        .sel_i(fb_bit), .pos_i(gb_pos), .neg_i(gb_neg), .prod_o(prod_b)
    );

    dcb_inner_mod #(.W(ST_W), .ORDER(LOOP_ORDER)) u_inner (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(valid_i),
        .a_i(a_cand), .bprod_i(prod_b), .fb_o(fb_bit)
    );

    always_comb begin
        st_d   = st_q;
        a_cand = ST_W'(clamp_int(int'(st_q.acc_a) + int'(prod_a), ST_W));
        u_sum  = clamp_int(int'(st_q.acc_u) + bit_val(bit_i) - bit_val(fb_bit)
                           - bit_val(st_q.y), ST_W);
        if (valid_i) begin
            st_d.acc_a = a_cand;
            st_d.acc_u = ST_W'(u_sum);
            st_d.y     = (u_sum >= 0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.acc_a <= '0;
            st_q.acc_u <= '0;
            st_q.y     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.y;

    // R3: no strobe, no movement of output or output integrator
    a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> $stable(bit_o) && $stable(st_q.acc_a) && $stable(st_q.acc_u));

    // R9: output integrator at its ceiling with a non-negative product does not wrap
    a_r9_acc_a_ceiling: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i && (int'(st_q.acc_a) == AMAX) && (int'(prod_a) >= 0)
        |=> int'(st_q.acc_a) == AMAX);

endmodule

// File: tb/bitstream_dc_blocker_test.sv
`timescale 1ns/1ps
module bitstream_dc_blocker_test;

    localparam int W    = 10;
    localparam int SMAX = 511;
    localparam int SMIN = -512;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic valid_i = 1'b0;
    logic bit_i = 1'b0;
    logic load_i = 1'b0;
    logic signed [W-1:0] alpha_i = '0;
    logic signed [W-1:0] beta_i = '0;
    logic out0, out1;

    always #10 clk = ~clk;

    bitstream_dc_blocker uut (
        .clk_i(clk), .rst_i(rst_i), .valid_i(valid_i), .bit_i(bit_i),
        .load_i(load_i), .alpha_i(alpha_i), .beta_i(beta_i), .bit_o(out0)
    );

    bitstream_dc_blocker #(.LOOP_ORDER(2)) uut_o2 (
        .clk_i(clk), .rst_i(rst_i), .valid_i(valid_i), .bit_i(bit_i),
        .load_i(load_i), .alpha_i(alpha_i), .beta_i(beta_i), .bit_o(out1)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Scoreboard queues
    bit    q_y0[$];
    bit    q_y1[$];
    string q_t0[$];
    string q_t1[$];

    // Independent fixed-point model, index 0 = one inner integrator, 1 = two
    int ma[2], mw1[2], mw2[2], mu[2], mga[2], mgb[2];
    bit my[2], ms[2];

    function automatic int sat(int v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    function automatic int neg_g(int g);
        return sat(-g);
    endfunction

    function automatic int pm(bit b);
        return b ? 1 : -1;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            ma[k] = 0; mw1[k] = 0; mw2[k] = 0; mu[k] = 0;
            my[k] = 1'b1; ms[k] = 1'b1;
        end
        mga[0] = 10; mgb[0] = 138;   // R7 defaults, one integrator
        mga[1] = 7;  mgb[1] = 26;    // R7 defaults, two integrators
    endtask

    task automatic model_step(int k, bit x);
        int pa, pb, a_n, w1_n, w2_n, u_n;
        bit s_n;
        pa   = my[k] ? mga[k] : neg_g(mga[k]);
        pb   = ms[k] ? mgb[k] : neg_g(mgb[k]);
        a_n  = sat(ma[k] + pa);
        w1_n = sat(mw1[k] + a_n - pb);
        w2_n = sat(mw2[k] + mw1[k] - pb);
        s_n  = (k == 0) ? (w1_n >= 0) : (w2_n >= 0);
        u_n  = sat(mu[k] + pm(x) - pm(ms[k]) - pm(my[k]));
        ma[k] = a_n; mw1[k] = w1_n; mw2[k] = w2_n; mu[k] = u_n;
        ms[k] = s_n; my[k] = (u_n >= 0);
    endtask

    // Driver: applies one cycle of stimulus, updates the model, pushes expectations
    task automatic drive(bit v, bit x, bit ld, int ga, int gb, string t0, string t1);
        @(negedge clk);
        valid_i = v; bit_i = x; load_i = ld;
        alpha_i = W'(ga); beta_i = W'(gb);
        @(posedge clk);
        #1;
        if (v) begin
            model_step(0, x);
            model_step(1, x);
        end
        if (ld) begin
            for (int k = 0; k < 2; k++) begin
                mga[k] = ga; mgb[k] = gb;
            end
        end
        q_y0.push_back(my[0]); q_t0.push_back(t0);
        q_y1.push_back(my[1]); q_t1.push_back(t1);
    endtask

    // Monitor: compares at the falling edge
    always @(negedge clk) begin
        if (q_y0.size() > 0) begin
            bit e0, e1;
            string s0, s1;
            e0 = q_y0.pop_front(); s0 = q_t0.pop_front();
            e1 = q_y1.pop_front(); s1 = q_t1.pop_front();
            total += 2;
            if (out0 !== e0) begin
                bad++;
                $display("FAIL %s order1 bit_o: actual=%0b expected=%0b", s0, out0, e0);
            end
            if (out1 !== e1) begin
                bad++;
                $display("FAIL %s order2 bit_o: actual=%0b expected=%0b", s1, out1, e1);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_i = 1'b1; valid_i = 1'b0; load_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_i = 1'b0;
        model_reset();
        @(negedge clk);
        // R2: output and feedback start at +1
        total += 2;
        if (out0 !== 1'b1) begin
            bad++; $display("FAIL R2 order1 reset bit_o: actual=%0b expected=1", out0);
        end
        if (out1 !== 1'b1) begin
            bad++; $display("FAIL R2 order2 reset bit_o: actual=%0b expected=1", out1);
        end
    endtask

    task automatic finish_run();
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        real acc, tgt;
        bit  xb, prevx;
        int  ysum, xsum;
        do_reset();

        // DC 0.5 plus tone, encoded by a first-order modulator; idle gaps every 8 steps
        acc = 0.0; prevx = 1'b0; ysum = 0; xsum = 0;
        for (int i = 0; i < 8192; i++) begin
            string t0, t1;
            tgt = 0.5 + 0.5 * $sin(2.0 * 3.141592653589793 * real'(i) / 64.0);
            acc = acc + tgt - real'(pm(prevx));
            xb  = (acc >= 0.0);
            prevx = xb;
            if (i % 8 == 7) drive(1'b0, ~xb, 1'b0, 0, 0, "R3", "R3");
            if (i < 16) begin t0 = "R4"; t1 = "R4"; end
            else if (i < 64) begin t0 = "R7"; t1 = "R7"; end
            else begin t0 = "R5"; t1 = "R6"; end
            drive(1'b1, xb, 1'b0, 0, 0, t0, t1);
            if (i >= 4096) begin
                ysum += pm(out0);
                xsum += pm(xb);
            end
        end
        // R10: settled output mean near zero while input mean is near 0.5
        total += 2;
        if (ysum > 512 || ysum < -512) begin
            bad++; $display("FAIL R10 output sum over 4096: actual=%0d expected=within +/-512", ysum);
        end
        if (xsum < 1600 || xsum > 2500) begin
            bad++; $display("FAIL R10 input sum over 4096: actual=%0d expected=about 2048", xsum);
        end

        // R1: alternating and lopsided patterns under default gains
        for (int i = 0; i < 200; i++)
            drive(1'b1, (i % 3) != 0, 1'b0, 0, 0, "R1", "R1");

        // R8: load together with a sample step, then load while idle
        drive(1'b1, 1'b1, 1'b1, 20, 100, "R8", "R8");
        for (int i = 0; i < 300; i++)
            drive(1'b1, (i % 5) < 3, 1'b0, 0, 0, "R8", "R8");
        drive(1'b0, 1'b0, 1'b1, 15, 60, "R8", "R8");
        for (int i = 0; i < 300; i++)
            drive(1'b1, (i % 4) != 0, 1'b0, 0, 0, "R8", "R8");

        // R9: zero beta and large alpha drive the integrators into the ceiling
        do_reset();
        drive(1'b0, 1'b0, 1'b1, 300, 0, "R9", "R9");
        for (int i = 0; i < 300; i++)
            drive(1'b1, 1'b1, 1'b0, 0, 0, "R9", "R9");
        drive(1'b0, 1'b0, 1'b1, 511, 511, "R9", "R9");
        for (int i = 0; i < 300; i++)
            drive(1'b1, (i % 7) == 0, 1'b0, 0, 0, "R9", "R9");

        done = 1;
        finish_run();
    end

endmodule